// File: doc/BRIEF.md
# Oversampled Serial Byte Receiver with Two-Entry Buffer

This block receives asynchronous serial frames of one low start bit, eight data bits sent least significant bit first, and one high stop bit. It takes its timing from a free-running one-cycle sample strobe. A mode input picks 16 or 8 strobes per bit period. The receiver aligns its bit timing to the first low sample that follows a high sample on the line. It takes three samples around the middle of each bit and keeps the majority value, so a single corrupted sample does not change the recovered bit.

Each finished byte goes into a small buffer together with its stop-bit error flag. A read strobe removes the oldest entry. A ready output stays high for as long as unread bytes remain. A sticky overrun flag records a byte that arrived while the buffer was full. When the enable input is low, the receiver abandons any frame in progress, empties the buffer and does not react to the line.

Top module: `osr_uart_rx`

## Requirements
- R1: After reset `rxReady` and `overrun` are 0, and `rxData` and `frameErr` read 0 while the buffer is empty.
- R2: With `dblSpeed` = 0 a bit period is 16 sample strobes. A frame made of a low start bit, data bits 0..7 in that order and a high stop bit is delivered on `rxData` with `frameErr` = 0.
- R3: With `dblSpeed` = 1 a bit period is 8 sample strobes, and frames are received exactly as in R2.
- R4: Each bit value is the majority of samples 8, 9 and 10 of its bit period in 16x mode, and of samples 4, 5 and 6 in 8x mode. Sample 1 is the start-detect sample. One wrong sample in the middle of a data bit does not change the received byte.
- R5: If the start bit votes high, the low pulse is a glitch. The receiver returns to idle, stores no byte, and receives the next frame correctly.
- R6: If the stop bit votes low, the byte is still stored, and `frameErr` = 1 is presented together with that byte.
- R7: The buffer holds two bytes. `rxReady` is 1 while at least one unread byte is present. A one-cycle `readStb` while `rxReady` = 1 pops the oldest byte, so bytes come out in arrival order. The head byte stays stable until it is popped.
- R8: A byte that completes while the buffer is full (and no pop happens in the same cycle) is dropped, and `overrun` becomes 1. `overrun` clears on the next pop or on disable.
- R9: While `rxEnable` is 0, the buffer is empty and `overrun` is 0 from the next clock on. A frame that is partly received when the enable drops is discarded.
- R10: While `rxEnable` is 0, activity on `rxdIn` stores no byte.
- R11: A start is recognised only on a low sample that follows a high sample seen while enabled. A line held low across re-enable produces no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxdIn | input | 1 | Serial line, idle high, synchronised inside |
| sampleTick | input | 1 | One-cycle sample strobe, 16 or 8 per bit |
| dblSpeed | input | 1 | 1 selects 8 samples per bit, 0 selects 16 |
| rxEnable | input | 1 | Receiver enable; low flushes and aborts |
| readStb | input | 1 | Pops the head byte when `rxReady` is 1 |
| rxData | output | 8 | Head byte of the buffer |
| rxReady | output | 1 | Unread data present |
| frameErr | output | 1 | Stop-bit error flag of the head byte |
| overrun | output | 1 | Sticky: a byte was dropped on a full buffer |

## Verification
A line change reaches the bit logic two clocks later, through the synchroniser. A byte enters the buffer on the clock after the strobe that carries the third stop-bit sample, so `rxReady` rises one clock after that strobe. A pop, an overrun and a disable-flush each show on the outputs one clock after the input that caused them. The bench drives the line at the falling edge in whole bit periods, each a multiple of the strobe spacing. A monitor samples at the falling edge, compares the head entry with the scoreboard and then issues a read, so each comparison happens only after the one-clock update has settled. Checks of absence (glitch, disable, held-low line) are made at least two bit periods after the stimulus, longer than any frame completion takes.

// File: rtl/osr_uart_pkg.sv
package osr_uart_pkg;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capVote;   // store current synchronised sample as a vote
    logic shiftIn;   // shift voted bit into the byte register
    logic pushByte;  // write assembled byte into the buffer
    logic stopErr;   // stop bit voted low on this push
    logic flush;     // empty buffer, clear overrun
  } rx_strobe_t;

endpackage

// File: rtl/osr_rx_fifo.sv
module osr_rx_fifo #(
  parameter int DEPTH  = 2,
  parameter int WIDTH  = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] wData,
  input  logic             pop,
  input  logic             flush,
  output logic [WIDTH-1:0] head,
  output logic             notEmpty,
  output logic             overrun
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] level;
  logic isFull, isEmpty, doPush, doPop;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : PTR_W'(p + 1'b1);
  endfunction

  assign isFull  = (level == CNT_W'(DEPTH));
  assign isEmpty = (level == '0);
  assign doPop   = pop && !isEmpty;
  assign doPush  = push && (!isFull || doPop);

  always_ff @(posedge clk) begin
    if (doPush && !flush) mem[wrPtr] <= wData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      level   <= '0;
      overrun <= 1'b0;
    end else if (flush) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      level   <= '0;
      overrun <= 1'b0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   level <= level + CNT_W'(1);
        2'b01:   level <= level - CNT_W'(1);
        default: level <= level;
      endcase
      if (push && isFull && !doPop) overrun <= 1'b1;
      else if (doPop)               overrun <= 1'b0;
    end
  end

  assign notEmpty = !isEmpty;
  assign head     = isEmpty ? '0 : mem[rdPtr];
endmodule

// File: rtl/osr_rx_datapath.sv
module osr_rx_datapath
  import osr_uart_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int FIFO_DEPTH  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxdIn,
  input  logic              readStb,
  input  rx_strobe_t        stb,
  output logic              rxS,
  output logic              liveMaj,
  output logic [DATA_W-1:0] rxData,
  output logic              rxReady,
  output logic              frameErr,
  output logic              overrun
);
  localparam int ENTRY_W = DATA_W + 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic [1:0]             votes;
  logic [DATA_W-1:0]      shiftQ;
  logic [ENTRY_W-1:0]     headEntry;

  // line synchroniser, idle high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], rxdIn};
  end
  assign rxS = syncQ[SYNC_STAGES-1];

  // two stored votes plus the live sample form the majority
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            votes <= 2'b11;
    else if (stb.capVote) votes <= {votes[0], rxS};
  end
  assign liveMaj = (votes[1] & votes[0]) | (votes[1] & rxS) | (votes[0] & rxS);

  // byte assembly, first bit received ends up in bit 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            shiftQ <= '0;
    else if (stb.shiftIn) shiftQ <= {liveMaj, shiftQ[DATA_W-1:1]};
  end

  osr_rx_fifo #(
    .DEPTH (FIFO_DEPTH),
    .WIDTH (ENTRY_W)
  ) u_fifo (
    .clk      (clk),
    .rstN     (rstN),
    .push     (stb.pushByte),
    .wData    ({stb.stopErr, shiftQ}),
    .pop      (readStb),
    .flush    (stb.flush),
    .head     (headEntry),
    .notEmpty (rxReady),
    .overrun  (overrun)
  );

  assign rxData   = headEntry[DATA_W-1:0];
  assign frameErr = headEntry[DATA_W];
endmodule

// File: rtl/osr_rx_ctrl.sv
module osr_rx_ctrl
  import osr_uart_pkg::*;
#(
  parameter int OSR_NORM = 16,
  parameter int OSR_DBL  = 8,
  parameter int DATA_W   = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleTick,
  input  logic       dblSpeed,
  input  logic       rxEnable,
  input  logic       rxS,
  input  logic       liveMaj,
  output rx_strobe_t stb
);
  localparam int CNT_W = $clog2(OSR_NORM + 1);
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  rx_state_e        state;
  logic [CNT_W-1:0] cnt, sNext, osr, voteA, voteB, voteLast;
  logic [BIT_W-1:0] bitIdx;
  logic             sawIdle;
  logic             active;

  assign osr      = dblSpeed ? CNT_W'(OSR_DBL) : CNT_W'(OSR_NORM);
  assign voteA    = osr >> 1;
  assign voteB    = voteA + CNT_W'(1);
  assign voteLast = voteA + CNT_W'(2);
  assign sNext    = cnt + CNT_W'(1);
  assign active   = rxEnable && sampleTick && (state != RX_IDLE);

  always_comb begin
    stb       = '0;
    stb.flush = !rxEnable;
    if (active) begin
      stb.capVote = (sNext == voteA) || (sNext == voteB);
      if (sNext == voteLast) begin
        stb.shiftIn  = (state == RX_DATA);
        stb.pushByte = (state == RX_STOP);
        stb.stopErr  = (state == RX_STOP) && !liveMaj;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= RX_IDLE;
      cnt     <= '0;
      bitIdx  <= '0;
      sawIdle <= 1'b0;
    end else if (!rxEnable) begin
      state   <= RX_IDLE;
      cnt     <= '0;
      bitIdx  <= '0;
      sawIdle <= 1'b0;
    end else if (sampleTick) begin
      case (state)
        RX_IDLE: begin
          if (rxS) begin
            sawIdle <= 1'b1;
          end else if (sawIdle) begin
            state   <= RX_START;
            cnt     <= CNT_W'(1);
            sawIdle <= 1'b0;
          end
        end
        RX_START: begin
          cnt <= sNext;
          if (sNext == voteLast && liveMaj) begin
            state <= RX_IDLE;
            cnt   <= '0;
          end else if (sNext == osr) begin
            state  <= RX_DATA;
            cnt    <= '0;
            bitIdx <= '0;
          end
        end
        RX_DATA: begin
          cnt <= sNext;
          if (sNext == osr) begin
            cnt <= '0;
            if (bitIdx == BIT_W'(DATA_W - 1)) state <= RX_STOP;
            else                              bitIdx <= bitIdx + BIT_W'(1);
          end
        end
        RX_STOP: begin
          cnt <= sNext;
          if (sNext == voteLast) begin
            state <= RX_IDLE;
            cnt   <= '0;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/osr_uart_rx.sv
module osr_uart_rx
  import osr_uart_pkg::*;
#(
  parameter int OSR_NORM    = 16,
  parameter int OSR_DBL     = 8,
  parameter int DATA_W      = 8,
  parameter int FIFO_DEPTH  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxdIn,
  input  logic              sampleTick,
  input  logic              dblSpeed,
  input  logic              rxEnable,
  input  logic              readStb,
  output logic [DATA_W-1:0] rxData,
  output logic              rxReady,
  output logic              frameErr,
  output logic              overrun
);
  rx_strobe_t stb;
  logic       rxS, liveMaj;

  osr_rx_ctrl #(
    .OSR_NORM (OSR_NORM),
    .OSR_DBL  (OSR_DBL),
    .DATA_W   (DATA_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sampleTick (sampleTick),
    .dblSpeed   (dblSpeed),
    .rxEnable   (rxEnable),
    .rxS        (rxS),
    .liveMaj    (liveMaj),
    .stb        (stb)
  );

  osr_rx_datapath #(
    .DATA_W      (DATA_W),
    .FIFO_DEPTH  (FIFO_DEPTH),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .rxdIn    (rxdIn),
    .readStb  (readStb),
    .stb      (stb),
    .rxS      (rxS),
    .liveMaj  (liveMaj),
    .rxData   (rxData),
    .rxReady  (rxReady),
    .frameErr (frameErr),
    .overrun  (overrun)
  );
endmodule

// File: rtl/osr_uart_rx_chk.sv
module osr_uart_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              rxEnable,
  input logic              readStb,
  input logic [DATA_W-1:0] rxData,
  input logic              rxReady,
  input logic              overrun
);
  // R9
  flush_on_disable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> (!rxReady && !overrun));

  // R10
  no_fill_disabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxReady) |-> $past(rxEnable));

  // R7
  ready_drop_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxReady) |-> ($past(readStb) || !$past(rxEnable)));

  // R7
  head_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rxReady) && !$past(readStb) && $past(rxEnable)) |-> (rxReady && $stable(rxData)));

  // R8
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(rxReady));

  // R8
  overrun_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(overrun) |-> ($past(readStb) || !$past(rxEnable)));
endmodule

bind osr_uart_rx osr_uart_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .rxEnable (rxEnable),
  .readStb  (readStb),
  .rxData   (rxData),
  .rxReady  (rxReady),
  .overrun  (overrun)
);

// File: tb/tb_osr_uart_rx.sv
`timescale 1ns/1ps
module tb_osr_uart_rx;
  localparam int TICK = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxdIn = 1'b1;
  logic       sampleTick = 1'b0;
  logic       dblSpeed = 1'b0;
  logic       rxEnable = 1'b0;
  logic       readStb = 1'b0;
  logic [7:0] rxData;
  logic       rxReady, frameErr, overrun;

  int  total = 0;
  int  bad = 0;
  int  osrNow = 16;
  bit  monOn = 1'b0;
  bit  finished = 1'b0;
  logic [8:0] expQ[$];

  osr_uart_rx dut (
    .clk(clk), .rstN(rstN), .rxdIn(rxdIn), .sampleTick(sampleTick),
    .dblSpeed(dblSpeed), .rxEnable(rxEnable), .readStb(readStb),
    .rxData(rxData), .rxReady(rxReady), .frameErr(frameErr), .overrun(overrun)
  );

  always #2.5 clk = ~clk;

  initial begin : tickGen
    int div = 0;
    forever begin
      @(negedge clk);
      sampleTick = (div == 0);
      div = (div == TICK - 1) ? 0 : div + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic expectByte(input logic [7:0] b, input logic err);
    expQ.push_back({err, b});
  endtask

  task automatic idleBits(input int n);
    rxdIn = 1'b1;
    repeat (n * osrNow * TICK) @(negedge clk);
  endtask

  // bit 0 start, 1..8 data, 9 stop; noiseBit flips one sample; abortBit drops enable
  task automatic sendFrame(input logic [7:0] b, input logic stopV, input int noiseBit, input int abortBit);
    int half;
    half = osrNow * TICK / 2;
    for (int i = 0; i < 10; i++) begin
      logic v;
      v = (i == 0) ? 1'b0 : (i == 9) ? stopV : b[i-1];
      if (i == abortBit) rxEnable = 1'b0;
      for (int c = 0; c < osrNow * TICK; c++) begin
        rxdIn = (i == noiseBit && c >= half && c < half + TICK) ? ~v : v;
        @(negedge clk);
      end
    end
    rxdIn = 1'b1;
  endtask

  task automatic waitDrain();
    for (int k = 0; k < 4000; k++) begin
      if (expQ.size() == 0 && !rxReady && !readStb) break;
      @(negedge clk);
    end
    chk(expQ.size() == 0, "R7 all expected bytes delivered", expQ.size(), 0);
  endtask

  // monitor: pops scoreboard and reads the head
  initial begin : monitor
    forever begin
      @(negedge clk);
      if (readStb) begin
        readStb = 1'b0;
      end else if (monOn && rxReady) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R7 unexpected byte", rxData, 0);
        end else begin
          logic [8:0] e;
          e = expQ.pop_front();
          chk(rxData == e[7:0], "R2 R3 R4 data byte", rxData, e[7:0]);
          chk(frameErr == e[8], "R6 frame error flag", frameErr, e[8]);
        end
        readStb = 1'b1;
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin : main
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rxReady == 1'b0, "R1 rxReady after reset", rxReady, 0);
    chk(overrun == 1'b0, "R1 overrun after reset", overrun, 0);
    chk(rxData == 8'h00 && frameErr == 1'b0, "R1 empty head reads zero", rxData, 0);

    rxEnable = 1'b1;
    monOn = 1'b1;
    idleBits(2);

    // R2 16x mode
    expectByte(8'hA5, 1'b0); sendFrame(8'hA5, 1'b1, -1, -1); idleBits(1);
    expectByte(8'h01, 1'b0); sendFrame(8'h01, 1'b1, -1, -1); idleBits(1);
    expectByte(8'hFE, 1'b0); sendFrame(8'hFE, 1'b1, -1, -1); idleBits(1);
    waitDrain();

    // R4 single bad mid-bit sample on several data bits
    expectByte(8'h5A, 1'b0); sendFrame(8'h5A, 1'b1, 3, -1); idleBits(1);
    expectByte(8'h0F, 1'b0); sendFrame(8'h0F, 1'b1, 8, -1); idleBits(1);
    waitDrain();

    // R6 stop bit low
    expectByte(8'h3C, 1'b1); sendFrame(8'h3C, 1'b0, -1, -1); idleBits(2);
    waitDrain();

    // R5 start glitch of two samples, then a good frame
    rxdIn = 1'b0;
    repeat (2 * TICK) @(negedge clk);
    idleBits(2);
    chk(rxReady == 1'b0 && expQ.size() == 0, "R5 glitch stores no byte", rxReady, 0);
    expectByte(8'h96, 1'b0); sendFrame(8'h96, 1'b1, -1, -1); idleBits(1);
    waitDrain();

    // R3 8x mode
    dblSpeed = 1'b1; osrNow = 8;
    idleBits(2);
    expectByte(8'hC3, 1'b0); sendFrame(8'hC3, 1'b1, -1, -1); idleBits(1);
    expectByte(8'h7E, 1'b0); sendFrame(8'h7E, 1'b1, 5, -1);  idleBits(1);
    expectByte(8'h24, 1'b1); sendFrame(8'h24, 1'b0, -1, -1); idleBits(2);
    waitDrain();
    dblSpeed = 1'b0; osrNow = 16;
    idleBits(2);

    // R8 overrun: three bytes, no reads
    monOn = 1'b0;
    sendFrame(8'h11, 1'b1, -1, -1); idleBits(1);
    sendFrame(8'h22, 1'b1, -1, -1); idleBits(1);
    chk(overrun == 1'b0, "R8 no overrun with two stored", overrun, 0);
    sendFrame(8'h33, 1'b1, -1, -1); idleBits(1);
    chk(rxReady == 1'b1, "R7 ready while unread", rxReady, 1);
    chk(overrun == 1'b1, "R8 overrun on full buffer", overrun, 1);
    chk(rxData == 8'h11, "R7 oldest byte at head", rxData, 8'h11);
    expectByte(8'h11, 1'b0); expectByte(8'h22, 1'b0);
    monOn = 1'b1;
    waitDrain();
    chk(overrun == 1'b0, "R8 overrun cleared by read", overrun, 0);

    // R9 flush on disable
    monOn = 1'b0;
    sendFrame(8'h44, 1'b1, -1, -1); idleBits(1);
    sendFrame(8'h55, 1'b1, -1, -1); sendFrame(8'h66, 1'b1, -1, -1); idleBits(1);
    chk(rxReady == 1'b1 && overrun == 1'b1, "R9 buffer full before disable", rxReady, 1);
    rxEnable = 1'b0;
    @(negedge clk);
    chk(rxReady == 1'b0, "R9 buffer emptied by disable", rxReady, 0);
    chk(overrun == 1'b0, "R9 overrun cleared by disable", overrun, 0);
    rxEnable = 1'b1;
    monOn = 1'b1;
    idleBits(2);

    // R9 abort mid-frame
    sendFrame(8'hE7, 1'b1, -1, 5);
    idleBits(1);
    rxEnable = 1'b1;
    idleBits(2);
    chk(rxReady == 1'b0 && expQ.size() == 0, "R9 partial frame discarded", rxReady, 0);

    // R10 line ignored while disabled
    rxEnable = 1'b0;
    idleBits(1);
    sendFrame(8'h81, 1'b1, -1, -1);
    idleBits(1);
    chk(rxReady == 1'b0, "R10 no byte while disabled", rxReady, 0);
    rxEnable = 1'b1;
    idleBits(1);
    expectByte(8'h69, 1'b0); sendFrame(8'h69, 1'b1, -1, -1); idleBits(1);
    waitDrain();

    // R11 line held low across re-enable
    rxEnable = 1'b0;
    rxdIn = 1'b0;
    repeat (osrNow * TICK) @(negedge clk);
    rxEnable = 1'b1;
    repeat (3 * osrNow * TICK) @(negedge clk);
    chk(rxReady == 1'b0, "R11 low line gives no start", rxReady, 0);
    idleBits(1);
    expectByte(8'hB4, 1'b0); sendFrame(8'hB4, 1'b1, -1, -1); idleBits(1);
    waitDrain();

    summary();
  end
endmodule